// File: doc/BRIEF.md
# Binary-to-Stochastic Randomizer Bank

This block converts unsigned fixed-point fractions into stochastic bit streams. In such a stream each bit is one with a probability equal to the fraction. The bank has several independent channels. Each channel owns a 10-bit pseudo-random sequence generator. Every clock, a channel compares its generator state against its captured value and emits one bit.

The generator is a maximal-length shift register with its feedback modified so that the all-zero state is entered once per pass. As a result, all 1024 states appear exactly once in every 1024 cycles. A one-cycle start pulse does three things: it captures every channel's input value, it reloads every generator with its own seed, and it opens an evaluation window of 1024 cycles. Within one window, the number of ones a channel emits equals its captured value exactly. Channels differ in seed and in the bit rotation applied before comparison, so two channels carrying the same value give distinct streams. Downstream stochastic logic can then treat the streams as independent inputs.

Each value field is one bit wider than the precision. This makes 1024/1024, a stream that is always one, representable.

Top module: `sng_bank`

## Requirements
- R1: While reset is held and after its release with no start pulse, `active_o` is 0 and every bit of `bits_o` is 0.
- R2: A start pulse sampled at a clock edge raises `active_o` from the next cycle. `active_o` then stays high for exactly 1024 cycles unless another start arrives.
- R3: Over one full window, channel k emits exactly v ones, where v is the unsigned value in bits [k*11+10 : k*11] of `val_i` captured at the start pulse, for 1 <= v <= 1023.
- R4: A captured value of 1024 or larger makes the channel emit 1 in every cycle of the window, for exactly 1024 ones.
- R5: A captured value of 0 makes the channel emit no ones during the window.
- R6: Changes of `val_i` after the start pulse have no effect on the streams of the running window.
- R7: A start pulse during a running window discards that window, captures the new values and opens a fresh full 1024-cycle window whose counts obey R3 to R5.
- R8: Outside a window, all stream bits are 0.
- R9: Two channels given the value 512 in the same window do not emit copies of one stream. The number of cycles in which both emit 1 lies between 224 and 288.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that captures values, reseeds and opens a window |
| val_i | input | NCH*(W+1) | Packed per-channel values, channel k in bits [k*(W+1)+W : k*(W+1)] |
| active_o | output | 1 | High during the 1024 cycles of an evaluation window |
| bits_o | output | NCH | One stochastic bit per channel per cycle |

## Verification
A restart pulse and ongoing stream emission can coincide: a start pulse that arrives in the middle of a window must clear the count and capture new values in the same edge that would otherwise continue the old sequence. The bench provokes this by pulsing start 300 cycles into a window with new values. It then judges that the following window lasts exactly 1024 cycles and that each channel's one-count matches the new values exactly. Value changes on the input in the middle of a window are provoked as well, and they are judged by exact counts against the values captured at start.

// File: rtl/sng_pkg.sv
package sng_pkg;

    // Nonzero seed per channel, spread over the state space.
    function automatic int unsigned chan_seed(input int unsigned ch, input int unsigned w);
        int unsigned span;
        span = (32'd1 << w) - 32'd1;
        return ((ch * 32'd43 + 32'd17) % span) + 32'd1;
    endfunction

    // Bit rotation applied to the generator state before comparison.
    function automatic int unsigned chan_rot(input int unsigned ch, input int unsigned w);
        return (ch * 32'd3) % w;
    endfunction

endpackage

// File: rtl/sng_lfsr.sv
module sng_lfsr #(
    parameter int unsigned     W    = 10,
    parameter logic [W-1:0]    TAPS = 10'h240,
    parameter logic [W-1:0]    SEED = 10'h011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] st_d, st_q;
    logic         fb;

    always_comb begin
        // Extra term at the all-but-MSB-zero states splices the zero state
        // into the cycle, giving a full 2^W period.
        fb   = (^(st_q & TAPS)) ^ (st_q[W-2:0] == '0);
        st_d = st_q;
        if (load_i) begin
            st_d = SEED;
        end else if (step_i) begin
            st_d = {st_q[W-2:0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

    // R3: the sequence never stalls on a state while stepping
    a_r3_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (st_q != $past(st_q)));

    // R3: the zero state is left toward state one, closing the full cycle
    a_r3_zero_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && st_q == '0) |=> (st_q == W'(1)));

endmodule

// File: rtl/sng_chan.sv
module sng_chan #(
    parameter int unsigned W   = 10,
    parameter int unsigned ROT = 0
) (
    input  logic [W-1:0] rnd_i,
    input  logic [W:0]   val_i,
    input  logic         en_i,
    output logic         bit_o
);

    logic [W-1:0] rnd_rot;

    generate
        if (ROT == 0) begin : g_plain
            assign rnd_rot = rnd_i;
        end else begin : g_rot
            assign rnd_rot = {rnd_i[W-1-ROT:0], rnd_i[W-1:W-ROT]};
        end
    endgenerate

    assign bit_o = en_i && ({1'b0, rnd_rot} < val_i);

endmodule

// File: rtl/sng_bank.sv
module sng_bank #(
    parameter int unsigned  NCH  = 4,
    parameter int unsigned  W    = 10,
    parameter logic [W-1:0] TAPS = 10'h240
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NCH*(W+1)-1:0] val_i,
    output logic                 active_o,
    output logic [NCH-1:0]       bits_o
);

    localparam int unsigned VW  = W + 1;
    localparam int unsigned WIN = 1 << W;

    typedef struct packed {
        logic                  active;
        logic [W-1:0]          cnt;
        logic [NCH*VW-1:0]     vals;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.vals   = val_i;
        end else if (st_q.active) begin
            st_d.cnt = st_q.cnt + W'(1);
            if (st_q.cnt == '1) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            localparam logic [W-1:0]  SEED_G = W'(sng_pkg::chan_seed(g, W));
            localparam int unsigned   ROT_G  = sng_pkg::chan_rot(g, W);
            logic [W-1:0] rnd;
            logic [VW-1:0] val_g;

            assign val_g = st_q.vals[g*VW +: VW];

            sng_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED_G)) i_lfsr (
                .clk     (clk),
                .rst_n   (rst_n),
                .load_i  (start_i),
                .step_i  (st_q.active),
                .state_o (rnd)
            );

            sng_chan #(.W(W), .ROT(ROT_G)) i_chan (
                .rnd_i (rnd),
                .val_i (val_g),
                .en_i  (st_q.active),
                .bit_o (bits_o[g])
            );

            // R5: a zero value never produces a one
            a_r5_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
                (active_o && val_g == '0) |-> !bits_o[g]);

            // R4: a full-scale value produces a one every cycle
            a_r4_full_on: assert property (@(posedge clk) disable iff (!rst_n)
                (active_o && val_g >= VW'(WIN)) |-> bits_o[g]);
        end
    endgenerate

    // R2: a start pulse opens a window on the next cycle
    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);

    // R2: the window closes after its last count
    a_r2_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && st_q.cnt == '1 && !start_i) |=> !active_o);

    // R6: captured values hold for the whole window
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !start_i) |=> $stable(st_q.vals));

    // R8: no stream activity outside a window
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (bits_o == '0));

endmodule

// File: tb/test_sng_bank.sv
module test_sng_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int W   = 10;
    localparam int VW  = W + 1;
    localparam int WIN = 1 << W;

    typedef struct {
        int    exp;
        string tag;
    } exp_item_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [NCH*VW-1:0]   val_i = '0;
    logic                active_o;
    logic [NCH-1:0]      bits_o;

    int tests_run = 0;
    int tests_failed = 0;
    bit finished = 0;

    exp_item_t sb_q[$];
    int  ones [NCH];
    int  win_cycles = 0;
    int  both_ones = 0;
    int  last_both = -1;
    bit  was_active = 0;

    sng_bank #(.NCH(NCH), .W(W)) i_sng_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .val_i    (val_i),
        .active_o (active_o),
        .bits_o   (bits_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    endtask

    task automatic set_vals(input int v0, input int v1, input int v2, input int v3);
        val_i[0*VW +: VW] = VW'(v0);
        val_i[1*VW +: VW] = VW'(v1);
        val_i[2*VW +: VW] = VW'(v2);
        val_i[3*VW +: VW] = VW'(v3);
    endtask

    // Driver: push expectations, then pulse start
    task automatic launch(input int v0, input int v1, input int v2, input int v3, input string mid_tag);
        int vs[NCH];
        vs = '{v0, v1, v2, v3};
        for (int k = 0; k < NCH; k++) begin
            exp_item_t it;
            it.exp = (vs[k] >= WIN) ? WIN : vs[k];
            if (mid_tag != "")       it.tag = mid_tag;
            else if (vs[k] == 0)     it.tag = "R5";
            else if (vs[k] >= WIN)   it.tag = "R4";
            else                     it.tag = "R3";
            sb_q.push_back(it);
        end
        @(posedge clk); #1;
        set_vals(v0, v1, v2, v3);
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    // Monitor: sample at the falling edge, compare against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (active_o) begin
                for (int k = 0; k < NCH; k++) ones[k] += int'(bits_o[k]);
                win_cycles++;
                if (bits_o[0] && bits_o[1]) both_ones++;
            end else begin
                check(bits_o == '0, "R8 idle bits", int'(bits_o), 0);
            end
            if (was_active && !active_o) begin
                check(win_cycles == WIN, "R2 window length", win_cycles, WIN);
                for (int k = 0; k < NCH; k++) begin
                    exp_item_t it;
                    if (sb_q.size() == 0) begin
                        check(0, "R3 scoreboard empty", ones[k], -1);
                    end else begin
                        it = sb_q.pop_front();
                        check(ones[k] == it.exp, $sformatf("%s ch%0d count", it.tag, k), ones[k], it.exp);
                    end
                end
                last_both = both_ones;
            end
            if (start_i) begin
                if (active_o) begin
                    // R7: aborted window expectations are discarded
                    for (int k = 0; k < NCH; k++) void'(sb_q.pop_front());
                end
                for (int k = 0; k < NCH; k++) ones[k] = 0;
                win_cycles = 0;
                both_ones = 0;
            end
            was_active = active_o;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int k = 0; k < NCH; k++) ones[k] = 0;
        // R1: reset state
        wait_cycles(3);
        #1;
        check(active_o == 1'b0, "R1 active in reset", int'(active_o), 0);
        check(bits_o == '0, "R1 bits in reset", int'(bits_o), 0);
        rst_n = 1'b1;
        wait_cycles(4);
        #1;
        check(active_o == 1'b0, "R1 active after reset", int'(active_o), 0);
        check(bits_o == '0, "R1 bits after reset", int'(bits_o), 0);

        // R3 R4 R5: boundary values
        launch(0, 1024, 1, 1023, "");
        wait_cycles(WIN + 4);

        // R9 with R4 overrange
        launch(512, 512, 300, 2047, "");
        wait_cycles(WIN + 4);
        check(last_both >= 224 && last_both <= 288, "R9 joint ones ch0/ch1", last_both, 256);

        // R6: inputs change mid-window
        launch(100, 777, 5, 640, "R6");
        wait_cycles(100);
        #1;
        set_vals(900, 2, 1024, 0);
        wait_cycles(WIN - 100 + 4);

        // R7: restart mid-window
        launch(10, 20, 30, 40, "");
        wait_cycles(300);
        launch(1000, 3, 999, 257, "R7");
        wait_cycles(WIN + 4);

        check(sb_q.size() == 0, "R7 scoreboard drained", sb_q.size(), 0);
        wait_cycles(5);
        finish_run();
    end

endmodule